// File: doc/BRIEF.md
# Per-Lane PHY Reset Sequencer

This controller puts one half of a 16-lane serial PHY through an ordered reset. A requester picks the half by presenting an internal lane mask and pulsing start. The block first stops the chosen lanes by clearing their bits in the run-lane vector. It then waits until those lanes report that they are no longer busy. Next it raises the receive and transmit io-reset vectors together for a single cycle. Last, it walks the lanes through a fixed list of read-modify-write updates on their per-lane configuration registers. These updates pulse the phase-rotator reset, restore the rotator phase step and the IQ resolution setting, and take the lanes out of their power-down states.

In the lane vectors, lane 0 is the most significant bit. Only a whole half may be selected. Because of that rule, the hardware-order vector is simply the bitwise inverse of the internal mask and needs no bit reversal. An illegal mask is rejected with an error flag and changes nothing. The configuration port has a fixed latency: read data for a read issued in one cycle is presented by the register side during the next cycle. In that next cycle the sequencer issues the matching write.

Top module: `lane_reset_seq`

## Requirements
- R1: After reset, run_vec_o is 0xFFFF, both io-reset vectors are 0, busy_o, done_o and err_o are 0, and no configuration access is issued.
- R2: The internal mask bit for lane n maps to hardware bit 15-n. For a legal mask, the hardware mask therefore equals the inverse of the internal mask. Two cycles after start is sampled, run_vec_o has exactly the hardware-mask bits cleared, and every other bit keeps its value.
- R3: The io-reset pulse is held off as long as any lane_busy_i bit inside the hardware mask is 1. lane_busy_i bits outside the mask are ignored.
- R4: The first rising edge at which the selected busy bits are all 0 sets rx_iorst_o and tx_iorst_o to the hardware mask at the same time. Both vectors return to 0 one cycle later.
- R5: Each update is a read with cfg_rd_o, followed in the next cycle by a write with cfg_wr_o to the same lane and register. The written value is (cfg_rdata_i & ~clear) | set, where cfg_rdata_i is sampled in the write cycle.
- R6: The updates run in a fixed order. The outer loop is the update list; the inner loop is lane index 0 to 23 in ascending order. Only lanes whose bit is set in the internal mask are accessed. For a legal mask this gives exactly 56 writes.
- R7: The update list, given as (register code, clear mask, set value), is: (0, 0x1000, 0x1000), (0, 0x1000, 0x0000), (1, 0x000F, 0x0008), (2, 0x0700, 0x0700), (3, 0x0001, 0), (4, 0x0080, 0), (5, 0x0020, 0).
- R8: A start with a mask other than 0x00FF or 0xFF00 sets err_o on the next cycle, leaves busy_o low, and leaves all vectors unchanged. The next legal start clears err_o.
- R9: busy_o is high from the cycle after an accepted start until the last write has completed; done_o then goes high and stays high until the next start. A start while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle |
| lane_mask_i | input | 16 | Internal lane mask, bit n is lane n |
| lane_busy_i | input | 16 | Lane busy vector, hardware order |
| run_vec_o | output | 16 | Run-lane vector, hardware order |
| rx_iorst_o | output | 16 | Receive io-reset vector |
| tx_iorst_o | output | 16 | Transmit io-reset vector |
| cfg_rd_o | output | 1 | Per-lane register read strobe |
| cfg_wr_o | output | 1 | Per-lane register write strobe |
| cfg_lane_o | output | 5 | Lane index of the access |
| cfg_reg_o | output | 3 | Register code of the access |
| cfg_wdata_o | output | 16 | Write data |
| cfg_rdata_i | input | 16 | Read data, valid the cycle after a read |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Last sequence completed |
| err_o | output | 1 | Last start had an illegal mask |

## Verification
Both halves are run, and the random register contents differ on every run. Each written value therefore shows whether the clear and set masks landed on the right bits of the right lane and register. The busy vector combines selected-lane bits held for a random number of cycles with random unselected bits. This separates a correct wait from one that stalls on foreign lanes or ignores its own lanes. Illegal masks, a zero-length busy wait and a start injected mid-sequence cover the rejection and ignore paths. A model compare on all 24 lanes after each run catches writes to lanes outside the selected half.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  localparam int CFG_W    = 16;
  localparam int REG_ID_W = 3;
  localparam int OP_COUNT = 7;
  localparam int OP_W     = $clog2(OP_COUNT);

  typedef struct packed {
    logic [REG_ID_W-1:0] reg_id;
    logic [CFG_W-1:0]    clr;
    logic [CFG_W-1:0]    set;
  } rmw_op_t;

  // Ordered update list: rotator reset pulse, then setting restores.
  function automatic rmw_op_t op_entry(input logic [OP_W-1:0] idx);
    rmw_op_t e;
    case (idx)
      3'd0:    e = '{reg_id: 3'd0, clr: 16'h1000, set: 16'h1000};
      3'd1:    e = '{reg_id: 3'd0, clr: 16'h1000, set: 16'h0000};
      3'd2:    e = '{reg_id: 3'd1, clr: 16'h000F, set: 16'h0008};
      3'd3:    e = '{reg_id: 3'd2, clr: 16'h0700, set: 16'h0700};
      3'd4:    e = '{reg_id: 3'd3, clr: 16'h0001, set: 16'h0000};
      3'd5:    e = '{reg_id: 3'd4, clr: 16'h0080, set: 16'h0000};
      3'd6:    e = '{reg_id: 3'd5, clr: 16'h0020, set: 16'h0000};
      default: e = '0;
    endcase
    return e;
  endfunction

  typedef enum logic [2:0] {C_IDLE, C_DROP, C_WAIT, C_PULSE, C_WALK} ctrl_st_t;
  typedef enum logic [1:0] {W_IDLE, W_SCAN, W_WR} walk_st_t;
endpackage

// File: rtl/lrs_mask_map.sv
module lrs_mask_map #(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0] int_mask_i,
  output logic              legal_o,
  output logic [LANE_W-1:0] hw_mask_o
);
  localparam int HALF = LANE_W / 2;
  localparam logic [LANE_W-1:0] LOW_HALF  = {{HALF{1'b0}}, {HALF{1'b1}}};
  localparam logic [LANE_W-1:0] HIGH_HALF = ~LOW_HALF;

  logic [LANE_W-1:0] rev_mask;

  // Reversed form, only used to guard the inversion shortcut.
  for (genvar g = 0; g < LANE_W; g++) begin : g_rev
    assign rev_mask[g] = int_mask_i[LANE_W-1-g];
  end

  assign legal_o   = (int_mask_i == LOW_HALF) || (int_mask_i == HIGH_HALF);
  assign hw_mask_o = ~int_mask_i;

  always_comb begin
    if (legal_o) begin
      AST_INV_EQ_REV: assert (hw_mask_o == rev_mask); // R2
    end
  end
endmodule

// File: rtl/lrs_ctrl.sv
module lrs_ctrl import lrs_pkg::*; #(
  parameter int LANE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LANE_W-1:0] int_mask_i,
  input  logic              legal_i,
  input  logic [LANE_W-1:0] hw_mask_i,
  input  logic [LANE_W-1:0] lane_busy_i,
  input  logic              walk_fin_i,
  output logic [LANE_W-1:0] int_mask_q_o,
  output logic [LANE_W-1:0] run_vec_o,
  output logic [LANE_W-1:0] rx_iorst_o,
  output logic [LANE_W-1:0] tx_iorst_o,
  output logic              walk_go_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  ctrl_st_t          st_q, st_d;
  logic [LANE_W-1:0] hw_q, int_q, run_q, rx_q, tx_q;
  logic              done_q, err_q;
  logic              accept, reject, drop_en, pulse_set, pulse_clr, done_set;
  logic              sel_busy;

  assign sel_busy = |(lane_busy_i & hw_q);

  always_comb begin
    st_d      = st_q;
    accept    = 1'b0;
    reject    = 1'b0;
    drop_en   = 1'b0;
    pulse_set = 1'b0;
    pulse_clr = 1'b0;
    walk_go_o = 1'b0;
    done_set  = 1'b0;
    case (st_q)
      C_IDLE: begin
        if (start_i) begin
          if (legal_i) begin
            accept = 1'b1;
            st_d   = C_DROP;
          end else begin
            reject = 1'b1;
          end
        end
      end
      C_DROP: begin
        drop_en = 1'b1;
        st_d    = C_WAIT;
      end
      C_WAIT: begin
        if (!sel_busy) begin
          pulse_set = 1'b1;
          st_d      = C_PULSE;
        end
      end
      C_PULSE: begin
        pulse_clr = 1'b1;
        walk_go_o = 1'b1;
        st_d      = C_WALK;
      end
      C_WALK: begin
        if (walk_fin_i) begin
          done_set = 1'b1;
          st_d     = C_IDLE;
        end
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= C_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_q  <= '0;
      int_q <= '0;
    end else if (accept) begin
      hw_q  <= hw_mask_i;
      int_q <= int_mask_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '1;
    else if (drop_en) run_q <= run_q & ~hw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
      tx_q <= '0;
    end else if (pulse_set) begin
      rx_q <= rx_q | hw_q;
      tx_q <= tx_q | hw_q;
    end else if (pulse_clr) begin
      rx_q <= rx_q & ~hw_q;
      tx_q <= tx_q & ~hw_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                done_q <= 1'b0;
    else if (accept || reject) done_q <= 1'b0;
    else if (done_set)         done_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (accept) err_q <= 1'b0;
    else if (reject) err_q <= 1'b1;
  end

  assign int_mask_q_o = int_q;
  assign run_vec_o    = run_q;
  assign rx_iorst_o   = rx_q;
  assign tx_iorst_o   = tx_q;
  assign busy_o       = (st_q != C_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;

  AST_RUN_LOW_DURING_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_q) |-> ((run_q & hw_q) == '0)); // R2
  AST_PULSE_AFTER_IDLE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|rx_q) |-> $past((lane_busy_i & hw_q) == '0)); // R3
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_q) |=> !(|rx_q)); // R4
endmodule

// File: rtl/lrs_rmw_walker.sv
module lrs_rmw_walker import lrs_pkg::*; #(
  parameter int LANE_W    = 16,
  parameter int NUM_SLOTS = 24,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_i,
  input  logic [LANE_W-1:0]   lane_mask_i,
  output logic                fin_o,
  output logic                cfg_rd_o,
  output logic                cfg_wr_o,
  output logic [SLOT_W-1:0]   cfg_lane_o,
  output logic [REG_ID_W-1:0] cfg_reg_o,
  output logic [CFG_W-1:0]    cfg_wdata_o,
  input  logic [CFG_W-1:0]    cfg_rdata_i
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [OP_W-1:0]   LAST_OP   = OP_W'(OP_COUNT - 1);

  walk_st_t             st_q, st_d;
  logic [OP_W-1:0]      op_q, op_d;
  logic [SLOT_W-1:0]    slot_q, slot_d;
  logic [NUM_SLOTS-1:0] mask_q;
  logic                 sel, step;
  rmw_op_t              cur;

  assign cur = op_entry(op_q);
  assign sel = mask_q[slot_q];

  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    slot_d = slot_q;
    fin_o  = 1'b0;
    step   = 1'b0;
    case (st_q)
      W_IDLE: begin
        if (go_i) begin
          st_d   = W_SCAN;
          op_d   = '0;
          slot_d = '0;
        end
      end
      W_SCAN: begin
        if (sel) st_d = W_WR;
        else     step = 1'b1;
      end
      W_WR:    step = 1'b1;
      default: st_d = W_IDLE;
    endcase
    if (step) begin
      st_d = W_SCAN;
      if (slot_q == LAST_SLOT) begin
        slot_d = '0;
        if (op_q == LAST_OP) begin
          st_d  = W_IDLE;
          fin_o = 1'b1;
        end else begin
          op_d = op_q + 1'b1;
        end
      end else begin
        slot_d = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      op_q   <= '0;
      slot_q <= '0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      slot_q <= slot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      mask_q <= '0;
    else if (go_i && st_q == W_IDLE) mask_q <= NUM_SLOTS'(lane_mask_i);
  end

  assign cfg_rd_o    = (st_q == W_SCAN) && sel;
  assign cfg_wr_o    = (st_q == W_WR);
  assign cfg_lane_o  = slot_q;
  assign cfg_reg_o   = cur.reg_id;
  assign cfg_wdata_o = (cfg_rdata_i & ~cur.clr) | cur.set;

  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_o |-> ($past(cfg_rd_o) && $stable(cfg_lane_o) && $stable(cfg_reg_o))); // R5
  AST_QUIET_AFTER_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> (!cfg_rd_o && !cfg_wr_o)); // R6
endmodule

// File: rtl/lane_reset_seq.sv
module lane_reset_seq import lrs_pkg::*; #(
  parameter int LANE_W    = 16,
  parameter int NUM_SLOTS = 24,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [LANE_W-1:0]   lane_mask_i,
  input  logic [LANE_W-1:0]   lane_busy_i,
  output logic [LANE_W-1:0]   run_vec_o,
  output logic [LANE_W-1:0]   rx_iorst_o,
  output logic [LANE_W-1:0]   tx_iorst_o,
  output logic                cfg_rd_o,
  output logic                cfg_wr_o,
  output logic [SLOT_W-1:0]   cfg_lane_o,
  output logic [REG_ID_W-1:0] cfg_reg_o,
  output logic [CFG_W-1:0]    cfg_wdata_o,
  input  logic [CFG_W-1:0]    cfg_rdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o
);
  logic              legal, walk_go, walk_fin;
  logic [LANE_W-1:0] hw_mask, int_mask_q;

  lrs_mask_map #(.LANE_W(LANE_W)) u_map (
    .int_mask_i (lane_mask_i),
    .legal_o    (legal),
    .hw_mask_o  (hw_mask)
  );

  lrs_ctrl #(.LANE_W(LANE_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .int_mask_i   (lane_mask_i),
    .legal_i      (legal),
    .hw_mask_i    (hw_mask),
    .lane_busy_i  (lane_busy_i),
    .walk_fin_i   (walk_fin),
    .int_mask_q_o (int_mask_q),
    .run_vec_o    (run_vec_o),
    .rx_iorst_o   (rx_iorst_o),
    .tx_iorst_o   (tx_iorst_o),
    .walk_go_o    (walk_go),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o)
  );

  lrs_rmw_walker #(.LANE_W(LANE_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (walk_go),
    .lane_mask_i (int_mask_q),
    .fin_o       (walk_fin),
    .cfg_rd_o    (cfg_rd_o),
    .cfg_wr_o    (cfg_wr_o),
    .cfg_lane_o  (cfg_lane_o),
    .cfg_reg_o   (cfg_reg_o),
    .cfg_wdata_o (cfg_wdata_o),
    .cfg_rdata_i (cfg_rdata_i)
  );

  AST_ERR_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o); // R8
  AST_DONE_MEANS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !cfg_rd_o && !cfg_wr_o)); // R9
  AST_ACCESS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_o || cfg_wr_o) |-> busy_o); // R9
endmodule

// File: tb/lane_reset_seq_tb_top.sv
`timescale 1ns/1ps
module lane_reset_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] lane_mask, lane_busy;
  logic [15:0] run_vec, rx_iorst, tx_iorst;
  logic        cfg_rd, cfg_wr;
  logic [4:0]  cfg_lane;
  logic [2:0]  cfg_reg;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        busy, done, err;

  always #2.5 clk = ~clk;

  lane_reset_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .lane_mask_i(lane_mask),
    .lane_busy_i(lane_busy), .run_vec_o(run_vec), .rx_iorst_o(rx_iorst),
    .tx_iorst_o(tx_iorst), .cfg_rd_o(cfg_rd), .cfg_wr_o(cfg_wr),
    .cfg_lane_o(cfg_lane), .cfg_reg_o(cfg_reg), .cfg_wdata_o(cfg_wdata),
    .cfg_rdata_i(cfg_rdata), .busy_o(busy), .done_o(done), .err_o(err)
  );

  int          n_chk = 0, n_fail = 0, wr_k = 0, rd_k = 0, cycles = 0;
  logic [15:0] cur_mask = 16'h00FF;
  logic [15:0] exp_run;
  logic [15:0] mdl  [24][6];
  logic [15:0] snap [24][6];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // R2: lane n -> hardware bit 15-n
  function automatic logic [15:0] hw_of(input logic [15:0] m);
    logic [15:0] h = '0;
    for (int n = 0; n < 16; n++) if (m[n]) h[15-n] = 1'b1;
    return h;
  endfunction

  // R7 update list
  function automatic int op_reg(input int k);
    int t[7] = '{0, 0, 1, 2, 3, 4, 5};
    return t[k];
  endfunction
  function automatic logic [15:0] op_clr(input int k);
    logic [15:0] t[7] = '{16'h1000, 16'h1000, 16'h000F, 16'h0700, 16'h0001, 16'h0080, 16'h0020};
    return t[k];
  endfunction
  function automatic logic [15:0] op_set(input int k);
    logic [15:0] t[7] = '{16'h1000, 16'h0000, 16'h0008, 16'h0700, 16'h0000, 16'h0000, 16'h0000};
    return t[k];
  endfunction
  function automatic int lane_of(input int k);
    return ((cur_mask == 16'h00FF) ? 0 : 8) + (k % 8);
  endfunction

  // Register-side responder and access monitor (R5, R6, R7)
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (cfg_rd) begin
        chk(int'(cfg_lane) == lane_of(rd_k) && int'(cfg_reg) == op_reg(rd_k / 8) && rd_k < 56,
            "R6 read lane/reg", {cfg_reg, cfg_lane}, {op_reg(rd_k / 8), lane_of(rd_k)});
        cfg_rdata = mdl[cfg_lane][cfg_reg];
        rd_k++;
      end
      if (cfg_wr) begin
        if (wr_k < 56) begin
          logic [15:0] e;
          e = (mdl[lane_of(wr_k)][op_reg(wr_k / 8)] & ~op_clr(wr_k / 8)) | op_set(wr_k / 8);
          chk(int'(cfg_lane) == lane_of(wr_k) && int'(cfg_reg) == op_reg(wr_k / 8),
              "R6 write lane/reg", {cfg_reg, cfg_lane}, {op_reg(wr_k / 8), lane_of(wr_k)});
          chk(cfg_wdata == e, "R5 write data", cfg_wdata, e);
        end else begin
          chk(1'b0, "R6 extra write", wr_k, 56);
        end
        mdl[cfg_lane][cfg_reg] = cfg_wdata;
        wr_k++;
      end
    end
  end

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk) if (cycles > 150000) begin
    chk(1'b0, "watchdog", cycles, 150000);
    report();
  end

  task automatic run_seq(input logic [15:0] m, input int hold, input bit inject);
    logic [15:0] hw, foreign, own, v;
    int errs, w;
    hw = hw_of(m);
    for (int l = 0; l < 24; l++)
      for (int r = 0; r < 6; r++) begin
        mdl[l][r]  = 16'($urandom);
        snap[l][r] = mdl[l][r];
      end
    cur_mask = m; wr_k = 0; rd_k = 0;
    foreign = 16'($urandom) & ~hw;
    own = 16'($urandom) & hw;
    if (own == 0) own = (hw == 16'hFF00) ? 16'h0100 : 16'h0001;
    lane_busy = foreign | ((hold > 0) ? own : 16'h0);
    @(negedge clk); start = 1'b1; lane_mask = m;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    chk(err == 1'b0, "R8 err cleared by legal start", err, 0);
    @(negedge clk);
    exp_run = exp_run & ~hw;
    chk(run_vec == exp_run, "R2 run lanes dropped", run_vec, exp_run);
    for (int h = 0; h < hold; h++) begin
      if (inject && h == 0) begin start = 1'b1; lane_mask = ~m; end
      else start = 1'b0;
      lane_busy = foreign | own;
      @(negedge clk);
      chk(rx_iorst == 16'h0, "R3 held while own lanes busy", rx_iorst, 0);
    end
    start = 1'b0;
    lane_busy = 16'($urandom) & ~hw;
    @(negedge clk);
    chk(rx_iorst == hw && tx_iorst == hw, "R4 io-reset raised", {rx_iorst, tx_iorst}, {hw, hw});
    @(negedge clk);
    chk(rx_iorst == 0 && tx_iorst == 0, "R4 io-reset dropped", {rx_iorst, tx_iorst}, 0);
    w = 0;
    while (!done && w < 600) begin @(negedge clk); w++; end
    chk(done == 1'b1 && busy == 1'b0, "R9 done and idle", {done, busy}, 2'b10);
    chk(wr_k == 56 && rd_k == 56, "R6 access count", wr_k, 56);
    chk(run_vec == exp_run, "R2 run vector kept (R9 ignored start)", run_vec, exp_run);
    errs = 0;
    for (int l = 0; l < 24; l++)
      for (int r = 0; r < 6; r++) begin
        v = snap[l][r];
        if (l < 16 && m[l])
          for (int k = 0; k < 7; k++) if (op_reg(k) == r) v = (v & ~op_clr(k)) | op_set(k);
        if (mdl[l][r] != v) errs++;
      end
    chk(errs == 0, "R7 final register image", errs, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; lane_mask = 16'h00FF; lane_busy = 16'h0; cfg_rdata = 16'h0;
    exp_run = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(run_vec == 16'hFFFF, "R1 run vector reset", run_vec, 16'hFFFF);
    chk(rx_iorst == 0 && tx_iorst == 0, "R1 io-reset reset", {rx_iorst, tx_iorst}, 0);
    chk({busy, done, err} == 3'b000, "R1 flags reset", {busy, done, err}, 0);
    chk(!cfg_rd && !cfg_wr, "R1 no access", {cfg_rd, cfg_wr}, 0);

    // R8: illegal masks
    foreach (lane_mask[i]) ;
    for (int t = 0; t < 2; t++) begin
      @(negedge clk); start = 1'b1; lane_mask = (t == 0) ? 16'h0F0F : 16'hFFFF;
      @(negedge clk); start = 1'b0;
      chk(err == 1'b1 && busy == 1'b0, "R8 illegal rejected", {err, busy}, 2'b10);
      @(negedge clk);
      chk(run_vec == exp_run && rx_iorst == 0, "R8 vectors untouched", run_vec, exp_run);
    end

    run_seq(16'h00FF, 0, 1'b0);
    run_seq(16'hFF00, 3, 1'b1);
    for (int it = 0; it < 6; it++)
      run_seq(($urandom % 2) ? 16'hFF00 : 16'h00FF, int'($urandom % 12), 1'($urandom));
    report();
  end
endmodule